// File: doc/BRIEF.md
# Coalescing Store Buffer with Read-Miss Bypass

This block sits between a write-through first-level cache and the next memory level. Processor stores enter a small queue whose entries each cover one memory block. Each entry holds a per-word valid mask and the word data. A store to a block that already has a queued entry, and that is not being handed to memory, is folded into that entry instead of taking a new slot. The queue empties in the background through a single memory command port. That port carries a block address, a per-word write mask and the full block of write data. Only words marked valid are written.

A read miss from the cache is presented on a lookup port, and every queued entry is compared against its block address. When no entry matches, the read goes to memory ahead of the queued writes. When a queued word covers the read, that word is returned at once from the buffer. When a block matches but the word is absent, the read is held back until the matching entries have drained, so memory never returns stale data.

Addresses are word addresses. The low log2(WORDS) bits select the word lane, and the upper bits form the block address. Lane w occupies bits [w*DW +: DW] of the write data, and bit w of the mask marks lane w.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the buffer is empty: no memory request, no stall and no read completion.
- R2: A store to a block with no mergeable entry takes a new entry. That entry drains as one write: the address is the block, the mask has only the stored word's bit set, and the data sits in that word's lane.
- R3: A store whose block matches a queued entry that is not being offered to memory merges into it. The entry then drains as one write whose mask is the union of the stored words, and a later store to the same word replaces the earlier value.
- R4: Entries are written to memory in the order they were allocated.
- R5: The buffer holds DEPTH (4) entries. A store that cannot merge while all entries are in use is refused with st_stall. A mergeable store is still accepted when the buffer is full.
- R6: The entry currently offered to memory accepts no merge. A store to its block takes a new entry, which drains later.
- R7: A read miss that matches no queued entry is issued to memory (mem_we low, mem_addr the read block) before the remaining queued writes. rd_done pulses in the cycle it is accepted.
- R8: A read miss whose word is held by a queued entry completes in the same cycle with rd_fwd high and rd_data equal to the youngest buffered value of that word, with no memory read.
- R9: A read miss whose block matches a queued entry that lacks the word is not issued to memory until every matching entry has drained; it is issued after them.
- R10: A write offered to memory keeps its address and mask until mem_ready accepts it, even if a read miss arrives meanwhile.
- R11: While entries are queued and no read miss is pending, the head entry is offered to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store present |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store refused this cycle; hold it |
| rd_req | input | 1 | Read miss lookup, held until rd_done |
| rd_addr | input | AW | Read miss word address |
| rd_done | output | 1 | Read miss served (forwarded or accepted by memory) |
| rd_fwd | output | 1 | Read served from the buffer |
| rd_data | output | DW | Forwarded word |
| mem_req | output | 1 | Memory command valid |
| mem_we | output | 1 | Command is a write (low: read) |
| mem_addr | output | AW-log2(WORDS) | Block address of the command |
| mem_wmask | output | WORDS | Per-word write enables |
| mem_wdata | output | WORDS*DW | Block write data |
| mem_ready | input | 1 | Memory accepts the command |

## Verification
On every cycle, the assertions check four things. A memory read never goes out while a queued entry matches its block. An offered write holds its address and mask until accepted, and always carries a nonzero mask. The stall appears only at full occupancy, and a forwarded read never coincides with a memory read. A queued entry with no pending read is always being offered. Only the bench scenarios can show the rest: the merged masks and lane data that reach memory, the drain order relative to a bypassing read, the value chosen when a word is forwarded, and that the entry being offered is not merged into.

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW = 32,
  parameter int AW = 16,
  localparam int OW = $clog2(WORDS),
  localparam int BW = AW - OW,
  localparam int PW = $clog2(DEPTH)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  output logic                st_stall,
  input  logic                rd_req,
  input  logic [AW-1:0]       rd_addr,
  output logic                rd_done,
  output logic                rd_fwd,
  output logic [DW-1:0]       rd_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [BW-1:0]       mem_addr,
  output logic [WORDS-1:0]    mem_wmask,
  output logic [WORDS*DW-1:0] mem_wdata,
  input  logic                mem_ready
);

  logic [BW-1:0]             e_blk [DEPTH];
  logic [WORDS-1:0]          e_msk [DEPTH];
  logic [WORDS-1:0][DW-1:0]  e_dat [DEPTH];
  logic [PW-1:0]             head, tail;
  logic [PW:0]               count;
  logic                      wr_lock;

  logic [DEPTH-1:0]          ev, st_hit, rd_hit;
  logic [DEPTH*BW-1:0]       blk_flat;
  logic                      merge_ok, fwd_ok, alloc, pop, full;
  logic                      rd_issue, wr_issue;
  logic [PW-1:0]             merge_idx;
  logic [DW-1:0]             fwd_val;

  wire [BW-1:0] st_blk = st_addr[AW-1:OW];
  wire [OW-1:0] st_w   = st_addr[OW-1:0];
  wire [BW-1:0] rd_blk = rd_addr[AW-1:OW];
  wire [OW-1:0] rd_w   = rd_addr[OW-1:0];

  assign full = (count == (PW+1)'(DEPTH));

  always_comb begin
    logic [PW-1:0] off;
    for (int i = 0; i < DEPTH; i++) begin
      off       = PW'(i) - head;
      ev[i]     = ({1'b0, off} < count);
      rd_hit[i] = ev[i] && (e_blk[i] == rd_blk);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign blk_flat[g*BW +: BW] = e_blk[g];
    end
  endgenerate

  assign rd_issue = rd_req && !(|rd_hit) && !wr_lock;
  assign wr_issue = !rd_issue && (count != '0);
  assign pop      = wr_issue && mem_ready;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      st_hit[i] = ev[i] && (e_blk[i] == st_blk) && !(wr_issue && (PW'(i) == head));
  end

  always_comb begin
    merge_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (st_hit[i]) merge_idx = PW'(i);
  end

  always_comb begin
    logic [PW-1:0] idx;
    fwd_ok  = 1'b0;
    fwd_val = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (rd_hit[idx] && e_msk[idx][rd_w]) begin
        fwd_ok  = 1'b1;
        fwd_val = e_dat[idx][rd_w];
      end
    end
  end

  assign merge_ok  = |st_hit;
  assign alloc     = st_valid && !merge_ok && !full;
  assign st_stall  = st_valid && !merge_ok && full;

  assign mem_req   = rd_issue || wr_issue;
  assign mem_we    = wr_issue;
  assign mem_addr  = rd_issue ? rd_blk : e_blk[head];
  assign mem_wmask = wr_issue ? e_msk[head] : '0;
  assign mem_wdata = e_dat[head];

  assign rd_fwd  = rd_req && fwd_ok;
  assign rd_data = fwd_val;
  assign rd_done = rd_fwd || (rd_issue && mem_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      wr_lock <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        e_blk[i] <= '0;
        e_msk[i] <= '0;
      end
    end else begin
      wr_lock <= wr_issue && !mem_ready;
      if (pop) head <= head + PW'(1);
      if (alloc) begin
        e_blk[tail] <= st_blk;
        e_msk[tail] <= WORDS'(1) << st_w;
        tail        <= tail + PW'(1);
      end else if (st_valid && merge_ok) begin
        e_msk[merge_idx][st_w] <= 1'b1;
      end
      count <= count + {{PW{1'b0}}, alloc} - {{PW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (alloc)                      e_dat[tail][st_w]      <= st_data;
    else if (st_valid && merge_ok)  e_dat[merge_idx][st_w] <= st_data;
  end

endmodule

// File: rtl/store_merge_buffer_chk.sv
module store_merge_buffer_chk #(
  parameter int DEPTH = 4,
  parameter int BW = 14,
  parameter int WORDS = 4,
  localparam int PW = $clog2(DEPTH)
)(
  input logic                clk,
  input logic                rst_n,
  input logic                st_stall,
  input logic                rd_req,
  input logic                rd_done,
  input logic                rd_fwd,
  input logic                mem_req,
  input logic                mem_we,
  input logic                mem_ready,
  input logic [BW-1:0]       mem_addr,
  input logic [WORDS-1:0]    mem_wmask,
  input logic [PW-1:0]       head,
  input logic [PW:0]         count,
  input logic [DEPTH*BW-1:0] blk_flat
);

  logic clash;
  always_comb begin
    logic [PW-1:0] off;
    clash = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      off = PW'(i) - head;
      if (({1'b0, off} < count) && (blk_flat[i*BW +: BW] == mem_addr)) clash = 1'b1;
    end
  end

  // R5
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> (count == (PW+1)'(DEPTH)));

  // R5
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH));

  // R9
  no_stale_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !clash);

  // R10
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ready) |=> (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wmask)));

  // R2
  nonempty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wmask != '0));

  // R8
  fwd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fwd |-> (rd_req && rd_done && !(mem_req && !mem_we)));

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != '0) && !rd_req) |-> (mem_req && mem_we));

endmodule

bind store_merge_buffer store_merge_buffer_chk #(.DEPTH(DEPTH), .BW(BW), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_stall(st_stall), .rd_req(rd_req), .rd_done(rd_done),
  .rd_fwd(rd_fwd), .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wmask(mem_wmask), .head(head), .count(count), .blk_flat(blk_flat));

// File: tb/sim_store_merge_buffer.sv
module sim_store_merge_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4, DW = 32, AW = 16, BW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, rd_req = 1'b0, mem_rdy = 1'b0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_stall, rd_done, rd_fwd, mem_req, mem_we;
  logic [DW-1:0] rd_data;
  logic [BW-1:0] mem_addr;
  logic [WORDS-1:0] mem_wmask;
  logic [WORDS*DW-1:0] mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_merge_buffer u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_stall(st_stall), .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
    .rd_fwd(rd_fwd), .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wmask(mem_wmask), .mem_wdata(mem_wdata), .mem_ready(mem_rdy));

  typedef struct packed {
    logic                we;
    logic [BW-1:0]       blk;
    logic [WORDS-1:0]    msk;
    logic [WORDS*DW-1:0] dat;
  } item_t;

  item_t q[$];
  string tq[$];
  int checks = 0, fails = 0;
  item_t e;
  string et;
  logic ok;

  function automatic logic [AW-1:0] wa(int blk, int w);
    return AW'(blk * WORDS + w);
  endfunction

  function automatic logic [WORDS*DW-1:0] ln(int w, logic [DW-1:0] d);
    return {{(WORDS-1)*DW{1'b0}}, d} << (w * DW);
  endfunction

  task automatic push_w(int blk, logic [WORDS-1:0] m, logic [WORDS*DW-1:0] d, string t);
    q.push_back('{we: 1'b1, blk: BW'(blk), msk: m, dat: d});
    tq.push_back(t);
  endtask

  task automatic push_r(int blk, string t);
    q.push_back('{we: 1'b0, blk: BW'(blk), msk: '0, dat: '0});
    tq.push_back(t);
  endtask

  task automatic check(string t, logic cond, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic wait_read();
    do @(negedge clk); while (!rd_done);
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
    check("R11 drained", !mem_req, 128'(mem_req), 128'(0));
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_rdy) begin
      if (q.size() == 0) begin
        check("R4 unexpected command", 1'b0, 128'(mem_addr), 128'(0));
      end else begin
        e = q.pop_front();
        et = tq.pop_front();
        ok = (mem_we == e.we) && (mem_addr == e.blk);
        if (e.we) begin
          ok &= (mem_wmask == e.msk);
          for (int l = 0; l < WORDS; l++)
            if (e.msk[l] && (mem_wdata[l*DW +: DW] != e.dat[l*DW +: DW])) ok = 1'b0;
        end else begin
          ok &= rd_done;
        end
        check(et, ok, {mem_we, 10'(mem_addr), 4'(mem_wmask), 113'(mem_wdata)},
                      {e.we, 10'(e.blk), 4'(e.msk), 113'(e.dat)});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset idle", !mem_req && !st_stall && !rd_done, {mem_req, st_stall, rd_done}, 0);
    @(posedge clk); #1;

    // Phase A: merge, full, stall, read bypass, FIFO order
    push_w(1, 4'b0001, ln(0, 32'hA0), "R2 single-word write");
    push_r(5, "R7 read bypasses queued writes");
    push_w(2, 4'b1010, ln(1, 32'hD0) | ln(3, 32'hC0), "R3 merged write");
    push_w(1, 4'b0100, ln(2, 32'hE0), "R6 no merge into offered entry");
    push_w(3, 4'b0101, ln(0, 32'hF0) | ln(2, 32'h60), "R5 merge while full, R4 order");
    store(wa(1, 0), 32'hA0);
    store(wa(2, 1), 32'hB0);
    store(wa(2, 3), 32'hC0);
    store(wa(2, 1), 32'hD0);
    store(wa(1, 2), 32'hE0);
    store(wa(3, 0), 32'hF0);
    st_valid = 1'b1; st_addr = wa(3, 2); st_data = 32'h60;
    @(negedge clk);
    check("R5 mergeable store accepted when full", !st_stall, 128'(st_stall), 128'(0));
    @(posedge clk); #1;
    st_addr = wa(4, 0); st_data = 32'h40;
    @(negedge clk);
    check("R5 stall when full", st_stall, 128'(st_stall), 128'(1));
    @(posedge clk); #1;
    st_valid = 1'b0;
    rd_req = 1'b1; rd_addr = wa(5, 0);
    @(negedge clk);
    check("R10 offered write held", mem_we && mem_addr == BW'(1) && !rd_done,
          {mem_we, 14'(mem_addr), rd_done}, {1'b1, 14'd1, 1'b0});
    @(posedge clk); #1;
    mem_rdy = 1'b1;
    wait_read();
    wait_drain();

    // Phase B: forwarding and conflicting read
    mem_rdy = 1'b0;
    push_w(6, 4'b0010, ln(1, 32'h11), "R8 head write after forward");
    push_w(7, 4'b0100, ln(2, 32'h33), "R9 matching entry drains first");
    push_r(7, "R9 read after matching drain");
    store(wa(6, 1), 32'h11);
    store(wa(7, 2), 32'h22);
    store(wa(7, 2), 32'h33);
    rd_req = 1'b1; rd_addr = wa(7, 2);
    @(negedge clk);
    check("R8 forward youngest", rd_done && rd_fwd && rd_data == 32'h33,
          {rd_done, rd_fwd, rd_data}, {1'b1, 1'b1, 32'h33});
    @(posedge clk); #1;
    rd_addr = wa(6, 1);
    @(negedge clk);
    check("R8 forward from head", rd_done && rd_fwd && rd_data == 32'h11,
          {rd_done, rd_fwd, rd_data}, {1'b1, 1'b1, 32'h11});
    @(posedge clk); #1;
    rd_addr = wa(7, 0);
    @(negedge clk);
    check("R9 conflict holds read", !rd_done && mem_we, {rd_done, mem_we}, 2'b01);
    repeat (2) @(negedge clk);
    check("R9 conflict still held", !rd_done && mem_we, {rd_done, mem_we}, 2'b01);
    @(posedge clk); #1;
    mem_rdy = 1'b1;
    wait_read();
    wait_drain();
    check("R4 all expected commands seen", q.size() == 0, 128'(q.size()), 128'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule